// File: doc/BRIEF.md
# Shared-Table Odd-Multiple Constant Multiplier Bank

This block multiplies one 8-bit unsigned sample by a fixed set of N constant coefficients at once. It serves as the multiplier bank of a direct-form FIR filter. Every output is the exact product of the same sample with its own coefficient. The delay line and the tap sum lie outside the block.

The sample is split into a low nibble and a high nibble. Each nibble passes through a single encoder that serves every coefficient. The encoder turns the nibble into three things: an odd-multiple index, a left-shift count and a zero flag. One read-only table holds N segments, and each segment stores the eight odd multiples 1, 3, ..., 15 of one coefficient. The table is read on two ports, one for each nibble.

For each coefficient, a recombiner takes the two segments that were read. It shifts each one and clears it when its nibble is zero. It then adds them, with the high part weighted by 16. The read stage and the add stage are both registered, so every product appears two cycles after its sample. A new sample may enter on every cycle.

Top module: `mcm_oms_bank`

## Requirements
- R1: While `rst_n` is low, every product field of `prod_o` reads zero one clock edge after the reset is sampled. This also holds when reset is asserted in the middle of a stream of samples.
- R2: Two rising edges after a sample is presented on `x_i`, product field k equals `x_i` × coefficient k exactly.
- R3: A new sample is accepted on every clock. Back-to-back samples produce back-to-back products, with the same two-cycle latency on all N outputs.
- R4: A zero nibble in either half contributes nothing to the product. The sample value 0 gives 0 on every output.
- R5: A sample whose low nibble is zero gives products whose four least significant bits are zero, equal to coefficient × high nibble × 16.
- R6: Even nibble values (2, 4, 6, 8, 10, 12, 14) are reconstructed exactly from a stored odd multiple shifted left by 1, 2 or 3 places.
- R7: The largest sample, 255, gives 255 × coefficient on every output with no truncation. Each product field is `CW + 8` bits wide.
- R8: Coefficient k occupies bits `[k*CW +: CW]` of parameter `COEFS`. Its product occupies bits `[k*(CW+8) +: CW+8]` of `prod_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x_i | input | 8 | Unsigned sample shared by all coefficients |
| prod_o | output | N*(CW+8) | N products packed side by side, coefficient 0 in the lowest field |

## Verification
The bench builds the block with N = 5, CW = 8 and coefficients 11, 23, 45, 125 and 187. The largest of these needs the full 8-bit coefficient width, so the widest products fill all 16 output bits. With five segments in the table, a wrong segment offset or a swapped port shows up as a wrong value in some field. Sweeping all 256 samples upward and then downward covers every odd index, every shift count and both zero clears on both ports. It also exercises back-to-back samples, and a reset in the middle of the stream checks that the pipeline clears.

// File: rtl/mcm_pkg.sv
// Shared definitions for the odd-multiple constant multiplier bank.
// Assumes an 8-bit sample split into two 4-bit halves.
package mcm_pkg;
    localparam int IN_W    = 8;
    localparam int HALF_W  = IN_W / 2;
    localparam int ODD_N   = 1 << (HALF_W - 1);
    localparam int ADDR_W  = HALF_W - 1;
    localparam int SHIFT_W = $clog2(HALF_W);

    // Lookup control for one nibble: table index, shift count, clear flag.
    typedef struct packed {
        logic               zero;
        logic [SHIFT_W-1:0] sh;
        logic [ADDR_W-1:0]  addr;
    } nib_ctl_t;
endpackage

// File: rtl/oms_encoder.sv
// Nibble encoder: strips trailing zeros from a nibble to find its odd part.
// The odd part's index selects the stored odd multiple, and the number of
// stripped zeros is the left shift that restores the nibble's value.
// Assumes a nibble of zero is flagged so the recombiner clears it.
module oms_encoder
    import mcm_pkg::*;
(
    input  logic [HALF_W-1:0] nib_i,
    output nib_ctl_t          ctl_o
);
    logic [HALF_W-1:0]  odd;
    logic [SHIFT_W-1:0] sh;

    // Count trailing zeros and derive the odd index.
    always_comb begin
        odd = nib_i;
        sh  = '0;
        for (int i = 0; i < HALF_W - 1; i++) begin
            if (!odd[0] && (nib_i != '0)) begin
                odd = odd >> 1;
                sh  = sh + 1'b1;
            end
        end
        ctl_o.zero = (nib_i == '0);
        ctl_o.sh   = sh;
        ctl_o.addr = odd[HALF_W-1:1];
    end
endmodule

// File: rtl/oms_table.sv
// Segmented dual-port odd-multiple table. Word w holds, for every
// coefficient k, the value COEF_k * (2w+1) in segment k of width CW+HALF_W.
// Both ports read the same contents; reads are registered.
// Assumes coefficients are unsigned and packed CW bits each in COEFS.
module oms_table
    import mcm_pkg::*;
#(
    parameter int               N     = 5,
    parameter int               CW    = 8,
    parameter logic [N*CW-1:0]  COEFS = '0,
    localparam int              SW    = CW + HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_a_i,
    input  logic [ADDR_W-1:0] addr_b_i,
    output logic [N*SW-1:0]   word_a_o,
    output logic [N*SW-1:0]   word_b_o
);
    logic [N*SW-1:0] rom [ODD_N];

    // Constant contents: odd multiples of each coefficient, segment by segment.
    always_comb begin
        for (int w = 0; w < ODD_N; w++) begin
            for (int k = 0; k < N; k++) begin
                rom[w][k*SW +: SW] = SW'(COEFS[k*CW +: CW] * SW'(2 * w + 1));
            end
        end
    end

    // Registered read on both ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_a_o <= '0;
            word_b_o <= '0;
        end else begin
            word_a_o <= rom[addr_a_i];
            word_b_o <= rom[addr_b_i];
        end
    end
endmodule

// File: rtl/oms_recombine.sv
// Per-coefficient recombiner: shifts each half's odd multiple back to its
// nibble value, clears a zero nibble, and adds the high half weighted by 16.
// Output is registered. Assumes controls arrive aligned with the segments.
module oms_recombine
    import mcm_pkg::*;
#(
    parameter int  CW = 8,
    localparam int SW = CW + HALF_W,
    localparam int PW = CW + IN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] seg_lo_i,
    input  logic [SW-1:0] seg_hi_i,
    input  nib_ctl_t      ctl_lo_i,
    input  nib_ctl_t      ctl_hi_i,
    output logic [PW-1:0] prod_o
);
    logic [PW-1:0] part_lo;
    logic [PW-1:0] part_hi;

    // Restore each half's partial product from its odd multiple.
    always_comb begin
        part_lo = ctl_lo_i.zero ? '0 : (PW'(seg_lo_i) << ctl_lo_i.sh);
        part_hi = ctl_hi_i.zero ? '0 : (PW'(seg_hi_i) << ctl_hi_i.sh);
    end

    // Register the weighted sum.
    always_ff @(posedge clk) begin
        if (!rst_n) prod_o <= '0;
        else        prod_o <= part_lo + (part_hi << HALF_W);
    end
endmodule

// File: rtl/mcm_oms_bank.sv
// Constant multiplier bank: one sample times N fixed coefficients.
// One encoder per nibble serves every coefficient; a single segmented table
// is read on two ports (low nibble on A, high nibble on B). Latency: two
// cycles from x_i to prod_o, one sample per cycle.
module mcm_oms_bank
    import mcm_pkg::*;
#(
    parameter int              N     = 5,
    parameter int              CW    = 8,
    parameter logic [N*CW-1:0] COEFS = {8'd187, 8'd125, 8'd45, 8'd23, 8'd11},
    localparam int             SW    = CW + HALF_W,
    localparam int             PW    = CW + IN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   x_i,
    output logic [N*PW-1:0]   prod_o
);
    nib_ctl_t        ctl_lo, ctl_hi;
    nib_ctl_t        ctl_lo_q, ctl_hi_q;
    logic [N*SW-1:0] word_lo, word_hi;

    oms_encoder u_enc_lo (.nib_i(x_i[HALF_W-1:0]),    .ctl_o(ctl_lo));
    oms_encoder u_enc_hi (.nib_i(x_i[IN_W-1:HALF_W]), .ctl_o(ctl_hi));

    oms_table #(.N(N), .CW(CW), .COEFS(COEFS)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_a_i (ctl_lo.addr),
        .addr_b_i (ctl_hi.addr),
        .word_a_o (word_lo),
        .word_b_o (word_hi)
    );

    // Carry shift and clear controls alongside the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_lo_q <= '0;
            ctl_hi_q <= '0;
        end else begin
            ctl_lo_q <= ctl_lo;
            ctl_hi_q <= ctl_hi;
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_coef
        oms_recombine #(.CW(CW)) u_rec (
            .clk      (clk),
            .rst_n    (rst_n),
            .seg_lo_i (word_lo[k*SW +: SW]),
            .seg_hi_i (word_hi[k*SW +: SW]),
            .ctl_lo_i (ctl_lo_q),
            .ctl_hi_i (ctl_hi_q),
            .prod_o   (prod_o[k*PW +: PW])
        );
    end
endmodule

// File: rtl/mcm_checker.sv
// Property checker for mcm_oms_bank, bound to every instance of it.
// Tracks cycles since reset so no property looks behind the reset.
module mcm_checker
    import mcm_pkg::*;
#(
    parameter int              N     = 5,
    parameter int              CW    = 8,
    parameter logic [N*CW-1:0] COEFS = '0,
    localparam int             PW    = CW + IN_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IN_W-1:0]   x_i,
    input logic [N*PW-1:0]   prod_o
);
    logic [1:0] live;

    // Saturating count of clock edges seen out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          live <= '0;
        else if (live != 2'd3) live <= live + 2'd1;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (prod_o == '0));

    a_r4_zero_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (live >= 2'd2 && $past(x_i, 2) == '0) |-> (prod_o == '0));

    a_r3_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 2'd3 && $past(x_i, 2) == $past(x_i, 3)) |-> $stable(prod_o));

    for (genvar k = 0; k < N; k++) begin : g_chk
        a_r2_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
            (live >= 2'd2) |->
            (prod_o[k*PW +: PW] == PW'(PW'($past(x_i, 2)) * PW'(COEFS[k*CW +: CW]))));

        a_r5_low_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (live >= 2'd2 && $past(x_i[HALF_W-1:0], 2) == '0) |->
            (prod_o[k*PW +: HALF_W] == '0));
    end
endmodule

bind mcm_oms_bank mcm_checker #(.N(N), .CW(CW), .COEFS(COEFS)) u_mcm_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .x_i    (x_i),
    .prod_o (prod_o)
);

// File: tb/tb_mcm_oms_bank.sv
// Bench: behavioural reference with a queue of pending samples, checked on
// every clock against x*C_k using the bench's own coefficient list.
module tb_mcm_oms_bank;
    localparam int N  = 5;
    localparam int CW = 8;
    localparam int PW = CW + 8;
    localparam int COEF [N] = '{11, 23, 45, 125, 187};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      x = '0;
    logic [N*PW-1:0] prod;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    int    q_x[$];
    string q_t[$];

    always #4 clk = ~clk;

    mcm_oms_bank #(
        .N(N), .CW(CW),
        .COEFS({8'd187, 8'd125, 8'd45, 8'd23, 8'd11})
    ) dut (
        .clk(clk), .rst_n(rst_n), .x_i(x), .prod_o(prod)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int v, input string base);
        if (v == 255)                     return "R7";
        if (v == 0)                       return "R4";
        if ((v & 15) == 0)                return "R5";
        if ((v >> 4) == 0)                return "R4";
        if ((v & 1) == 0 || (v & 16) == 0) return "R6";
        return base;
    endfunction

    // One clock: check the sample from two clocks back, then drive a new one.
    task automatic step(input int v, input string base);
        @(negedge clk);
        if (q_x.size() == 2) begin
            int    e = q_x.pop_front();
            string t = q_t.pop_front();
            for (int k = 0; k < N; k++)
                check(tag_of(e, t), int'(prod[k*PW +: PW]), e * COEF[k]);
        end
        x = 8'(v);
        q_x.push_back(v);
        q_t.push_back(base);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs zero under reset
        for (int k = 0; k < N; k++) check("R1", int'(prod[k*PW +: PW]), 0);
        rst_n = 1'b1;
        // R2/R6/R4/R5/R7: full ascending sweep
        for (int v = 0; v < 256; v++) step(v, "R2");
        // R3: back-to-back descending sweep
        for (int v = 255; v >= 0; v--) step(v, "R3");
        step(0, "R3");
        step(0, "R3");
        // R1: reset in the middle of a stream
        step(200, "R2");
        step(77, "R2");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int k = 0; k < N; k++) check("R1", int'(prod[k*PW +: PW]), 0);
        q_x.delete();
        q_t.delete();
        rst_n = 1'b1;
        // R8: field placement, sample 1 exposes each coefficient in its slot
        step(1, "R8");
        step(0, "R8");
        @(negedge clk);
        check("R8", int'(prod[4*PW +: PW]), 187);
        check("R8", int'(prod[0*PW +: PW]), 11);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule